// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Interrupt

This block holds two identical down-counting timer channels behind one register bus that spans a 4 KB window. Bytes 0x00 to 0x1F of the window belong to channel 0. Bytes 0x20 to 0x3F belong to channel 1, and the address is rebased by 0x20 before that channel decodes it. The rest of the window is empty. Both channels count on a shared tick-enable input, which stands for a 1 MHz reference. Each channel can divide that reference by 1, 16 or 256.

Each channel runs in one of three ways:

- Periodic: it reloads from its limit register when it expires.
- One-shot: it stops at zero and clears its own enable bit.
- Free-running: it wraps to the all-ones value of the selected width, either 16 or 32 bits.

An expiry latches a pending flag. Masking that flag with the channel's interrupt-enable bit gives the channel's interrupt. The two channel interrupts are ORed onto the single `irq` output.

Within a channel the word registers are:

| Offset | Access | Function |
|---|---|---|
| 0x00 | read/write | Limit. A write also reloads the counter. |
| 0x04 | read-only | Current count. |
| 0x08 | read/write | Control. |
| 0x0C | write | Clear pending. |
| 0x10 | read | Raw pending. |
| 0x14 | read | Masked pending. |
| 0x18 | read/write | Limit, written without reloading the counter. |
| 0x1C | none | Unused. |

The control register bits are:

| Bit | Function |
|---|---|
| 0 | enable |
| 1 | interrupt enable |
| 2 | periodic |
| 3 | one-shot |
| 4 | 32-bit width |
| 6:5 | prescale: 0 is /1, 1 is /16, 2 or 3 is /256 |

Top module: `dual_timer`

## Requirements
- R1: Byte offsets 0x00-0x1F address channel 0 and 0x20-0x3F address channel 1 at the same relative offsets. Any offset from 0x40 up reads zero, and a write there changes no register.
- R2: A write to offset 0x00 sets the limit and reloads the counter at once; the limit reads back at 0x00 and at 0x18. A write to 0x18 sets the limit and leaves the counter unchanged.
- R3: While bit 0 of control is set, each prescaled tick lowers the count by one. A tick that finds the count at 1 or 0 sets pending and, in periodic mode (bit 2), reloads the limit. The count changes only on a tick or a bus write.
- R4: With bits 6:5 equal to 1 the counter steps on every 16th tick; with 2 it steps on every 256th. Writing control or the limit restarts the prescaler.
- R5: In one-shot mode (bit 3) an expiry leaves the count at 0 and clears control bit 0. Later ticks leave the count at 0.
- R6: With bits 2 and 3 both clear, a reload, a limit write or an enabling control write sets the count to 0xFFFF, or to 0xFFFFFFFF when bit 4 is set.
- R7: Offset 0x10 reads the pending flag and 0x14 reads it ANDed with control bit 1. Any write to 0x0C clears pending, but a tick expiry in the same cycle wins. `irq` rises only after a tick or a write.
- R8: `irq` is high exactly when either channel has pending set together with its control bit 1.
- R9: Writes to the count register (0x04) are ignored. Offset 0x1C reads zero and ignores writes.
- R10: After reset each channel reads control 0x02 and limit, count and pending 0, and `irq` is low.
- R11: With bit 4 clear, a reload loads only the low 16 bits of the limit. The limit register itself keeps all 32 bits.
- R12: A control write with bit 0 set reloads the counter for the new mode. With bit 0 clear the count is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Reference tick, one clock wide per 1 MHz period |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en`, zero otherwise |
| irq | output | 1 | OR of both channels' masked interrupts |

## Verification
The properties assume single-cycle, mutually exclusive read and write strobes. They also assume that `tick_en` is a one-clock pulse which never coincides with a bus write the checks depend on. The stimulus separates every access and every tick by an idle cycle, so no write lands on a tick edge. The stimulus walks both channels through periodic, one-shot and free-running operation, all three prescale settings and both widths. It also probes the unused and out-of-range offsets.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int DW     = 32,
  parameter int AW     = 12,
  parameter int N_CH   = 2,
  parameter int STRIDE = 32,
  parameter int PW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int OW   = $clog2(STRIDE);
  localparam int CHW  = AW - OW;
  localparam int RW   = OW - 2;
  localparam int CFW  = 7;
  localparam int B_EN = 0, B_IE = 1, B_PER = 2, B_ONE = 3, B_WIDE = 4, B_PS = 5;
  localparam logic [CFW-1:0] CTRL_RST = 7'h02;
  localparam logic [RW-1:0] R_LOAD = 0, R_VAL = 1, R_CTRL = 2, R_CLR = 3,
                            R_RAW = 4, R_MSK = 5, R_BG = 6;

  wire [CHW-1:0] ch_idx  = addr[AW-1:OW];
  wire [RW-1:0]  reg_idx = addr[OW-1:2];

  logic [DW-1:0]  cnt_q   [N_CH];
  logic [DW-1:0]  lim_q   [N_CH];
  logic [CFW-1:0] ctrl_q  [N_CH];
  logic [N_CH-1:0] pend_q;
  logic [N_CH-1:0] mis;

  function automatic logic [DW-1:0] reload_of(input logic [CFW-1:0] cf,
                                              input logic [DW-1:0] lim);
    logic [DW-1:0] m;
    m = cf[B_WIDE] ? '1 : DW'(16'hFFFF);
    if (!cf[B_PER] && !cf[B_ONE]) return m;
    return lim & m;
  endfunction

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [DW-1:0]  cnt, lim;
    logic [CFW-1:0] ctrl;
    logic [PW-1:0]  pre;
    logic           pend, hit, step;
    wire            wr_c = wr_en && (ch_idx == CHW'(c));

    always_comb begin
      case (ctrl[B_PS+1:B_PS])
        2'd0:    hit = 1'b1;
        2'd1:    hit = &pre[3:0];
        default: hit = &pre;
      endcase
    end
    assign step = tick_en && ctrl[B_EN] && hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        lim  <= '0;
        ctrl <= CTRL_RST;
        pre  <= '0;
        pend <= 1'b0;
      end else begin
        if (!ctrl[B_EN])  pre <= '0;
        else if (tick_en) pre <= pre + 1'b1;
        if (wr_c && reg_idx == R_CLR) pend <= 1'b0;
        if (step) begin
          if (cnt <= DW'(1)) begin
            pend <= 1'b1;
            if (ctrl[B_ONE]) begin
              cnt        <= '0;
              ctrl[B_EN] <= 1'b0;
            end else begin
              cnt <= reload_of(ctrl, lim);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (wr_c) begin
          case (reg_idx)
            R_LOAD: begin
              lim <= wdata;
              cnt <= reload_of(ctrl, wdata);
              pre <= '0;
            end
            R_CTRL: begin
              ctrl <= wdata[CFW-1:0];
              pre  <= '0;
              if (wdata[B_EN]) cnt <= reload_of(wdata[CFW-1:0], lim);
            end
            R_BG:    lim <= wdata;
            default: ;
          endcase
        end
      end
    end

    assign cnt_q[c]  = cnt;
    assign lim_q[c]  = lim;
    assign ctrl_q[c] = ctrl;
    assign pend_q[c] = pend;
    assign mis[c]    = pend & ctrl[B_IE];
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (rd_en && ch_idx == CHW'(c)) begin
        case (reg_idx)
          R_LOAD, R_BG: rdata = lim_q[c];
          R_VAL:        rdata = cnt_q[c];
          R_CTRL:       rdata = DW'(ctrl_q[c]);
          R_RAW:        rdata = DW'(pend_q[c]);
          R_MSK:        rdata = DW'(mis[c]);
          default:      rdata = '0;
        endcase
      end
    end
  end

  assign irq = |mis;
endmodule

// File: rtl/dual_timer_sva.sv
module dual_timer_sva #(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [DW-1:0] cnt0,
  input logic [6:0]    ctrl0
);
  assert_hole_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= AW'(12'h040)) |-> rdata == '0);

  assert_pad_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr < AW'(12'h040) && addr[4:2] == 3'd7) |-> rdata == '0);

  assert_value_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12'h004) && !tick_en) |=> $stable(cnt0));

  assert_count_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(cnt0));

  assert_oneshot_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == '0 && ctrl0[3] && !wr_en) |=> cnt0 == '0);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick_en || wr_en));
endmodule

bind dual_timer dual_timer_sva #(.DW(DW), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .rdata(rdata), .irq(irq), .cnt0(cnt_q[0]), .ctrl0(ctrl_q[0])
);

// File: tb/dual_timer_test.sv
module dual_timer_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  dual_timer uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
                  .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk); #(CLK_P/4);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  initial begin : monitor
    logic [31:0] e;
    string t;
    forever begin
      @(negedge clk); #(CLK_P/4);
      if (rd_en) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL unexpected read actual=%h expected=none", rdata);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (rdata !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", t, rdata, e);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(12'h008, 32'h02, "R10 ctrl0");
    rd(12'h004, 32'h0,  "R10 count0");
    rd(12'h010, 32'h0,  "R10 raw0");
    rd(12'h028, 32'h02, "R10 ctrl1");
    chk_irq(1'b0, "R10");
    // R11 / R2 16-bit periodic load, background load, R12 disabled hold
    wr(12'h008, 32'h06);
    wr(12'h000, 32'h12345);
    rd(12'h000, 32'h12345, "R11 limit keeps 32 bits");
    rd(12'h004, 32'h2345,  "R11 count masked");
    wr(12'h018, 32'h10);
    rd(12'h004, 32'h2345, "R2 bg load keeps count");
    rd(12'h000, 32'h10,   "R2 limit via load offset");
    // R3 periodic countdown, R12 enabling reload
    wr(12'h008, 32'h17);
    rd(12'h004, 32'h10, "R12 enable reloads");
    wr(12'h000, 32'h5);
    tick(4);
    rd(12'h004, 32'h1, "R3 count after 4 ticks");
    chk_irq(1'b0, "R3 before expiry");
    tick(1);
    rd(12'h004, 32'h5, "R3 periodic reload");
    rd(12'h010, 32'h1, "R7 raw set");
    rd(12'h014, 32'h1, "R7 masked set");
    chk_irq(1'b1, "R8 ch0");
    // R7 masking and clear
    wr(12'h008, 32'h15);
    rd(12'h014, 32'h0, "R7 masked off");
    rd(12'h010, 32'h1, "R7 raw kept");
    chk_irq(1'b0, "R7 mask");
    wr(12'h00C, 32'h0);
    rd(12'h010, 32'h0, "R7 clear");
    // R1 / R8 channel 1
    wr(12'h020, 32'h3);
    rd(12'h024, 32'hFFFF, "R6 ch1 free-run load");
    wr(12'h028, 32'h17);
    tick(3);
    rd(12'h030, 32'h1, "R1 ch1 raw");
    rd(12'h010, 32'h0, "R1 ch0 raw untouched");
    rd(12'h004, 32'h2, "R1 ch0 count");
    chk_irq(1'b1, "R8 ch1");
    wr(12'h02C, 32'h0);
    chk_irq(1'b0, "R8 ch1 cleared");
    wr(12'h008, 32'h14);
    wr(12'h028, 32'h16);
    rd(12'h028, 32'h16, "R1 ch1 ctrl");
    // R4 prescale
    wr(12'h008, 32'h37);
    wr(12'h000, 32'h2);
    tick(15);
    rd(12'h004, 32'h2, "R4 div16 early");
    tick(1);
    rd(12'h004, 32'h1, "R4 div16 step");
    wr(12'h008, 32'h57);
    tick(255);
    rd(12'h004, 32'h2, "R4 div256 early");
    tick(1);
    rd(12'h004, 32'h1, "R4 div256 step");
    // R5 one-shot
    wr(12'h008, 32'h1B);
    wr(12'h000, 32'h3);
    tick(3);
    rd(12'h008, 32'h1A, "R5 enable cleared");
    rd(12'h004, 32'h0,  "R5 count zero");
    rd(12'h010, 32'h1,  "R5 pending");
    chk_irq(1'b1, "R5 irq");
    tick(2);
    rd(12'h004, 32'h0, "R5 stays zero");
    wr(12'h00C, 32'h0);
    chk_irq(1'b0, "R7 clear one-shot");
    // R6 free-running
    wr(12'h008, 32'h03);
    rd(12'h004, 32'hFFFF, "R6 16-bit max");
    tick(1);
    rd(12'h004, 32'hFFFE, "R6 decrement");
    wr(12'h008, 32'h13);
    rd(12'h004, 32'hFFFFFFFF, "R6 32-bit max");
    wr(12'h000, 32'h7);
    rd(12'h004, 32'hFFFFFFFF, "R6 load in free-run");
    rd(12'h000, 32'h7, "R6 limit stored");
    wr(12'h008, 32'h12);
    // R9 ignored writes
    wr(12'h004, 32'h55);
    rd(12'h004, 32'hFFFFFFFF, "R9 count write ignored");
    rd(12'h01C, 32'h0, "R9 pad reads zero");
    wr(12'h01C, 32'h99);
    rd(12'h000, 32'h7,  "R9 pad write ignored limit");
    rd(12'h008, 32'h12, "R9 pad write ignored ctrl");
    // R1 out-of-range
    rd(12'h040, 32'h0, "R1 hole read");
    wr(12'h040, 32'hAA);
    wr(12'h048, 32'h17);
    rd(12'h000, 32'h7,  "R1 hole write ch0");
    rd(12'h020, 32'h3,  "R1 hole write ch1");
    rd(12'h028, 32'h16, "R1 hole write ch1 ctrl");
    rd(12'hFFC, 32'h0,  "R1 top read");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule